// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block tracks which of five power modes a small microcontroller occupies and drives the gating outputs for its two power domains. The first domain is the fast domain, which holds the CPU, the memories and the fast peripherals. The second is the slow domain, which holds the low-speed peripherals. The block also drives the core regulator enable and a CPU clock enable. Software asks for a lower-power mode by presenting a one-cycle request with a mode code. The sequencer then removes clocks first and power one cycle later. The outputs settle to the pattern that belongs to the chosen mode.

A qualified wake event returns the block to the active mode. On wake, power comes back at once. The clocks that were off stay off for a programmable settle count, and then they return. Deep shutdown is stricter than the other low-power modes. Only a debug-port wake, an external-reset wake or a level match on one of the designated IO inputs can end it, and peripheral interrupts have no effect there. Leaving shutdown raises a flag that tells software the domains lost their configuration. Software clears that flag once it has set the domains up again.

Top module: `lpm_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, the block is in RUN. `mode_code` is 0, all six enables are 1, and `reinit_req` is 0.
- R2: A request (`req_valid`=1) is accepted only while the block is settled in RUN and only for `req_mode` 1 to 4. Codes 0, 5, 6 and 7 are ignored, and so is any request made in another mode or during a transition. An ignored request leaves `mode_code` and every enable unchanged.
- R3: Once settled, the outputs in the order {cpu_clk_en, hp_clk_en, hp_pwr_en, ls_clk_en, ls_pwr_en, core_reg_en} are: RUN 111111, SLEEP 011111, STOP 000111, STANDBY 000011, SHUTDOWN 000000.
- R4: In the first cycle after a request is accepted, the three clock enables already take the target mode's values while the power enables and `core_reg_en` are still 1. The power enables reach the target pattern one cycle later.
- R5: While settled in SLEEP, STOP or STANDBY, `periph_wake` or any shutdown wake source (below) returns the block to RUN.
- R6: While settled in SHUTDOWN, only `dbg_wake`, `ext_rst_wake` or a 1 on any bit of `io_match` wakes the block. `periph_wake` alone leaves the block in SHUTDOWN with every enable at 0.
- R7: At the wake edge, `mode_code` becomes 0 and all power enables and `core_reg_en` become 1. The clock enables keep the low-power mode's values for `settle_cnt`+1 cycles, with `settle_cnt` sampled at the wake edge. After that, all enables are 1.
- R8: `mode_code` reports 0=RUN, 1=SLEEP, 2=STOP, 3=STANDBY and 4=SHUTDOWN. It changes at the edge where a request is accepted or a wake is taken.
- R9: `reinit_req` becomes 1 at a wake out of SHUTDOWN, including when `reinit_clr` is high in that same cycle. Otherwise, `reinit_clr`=1 clears it at the next edge. A wake out of any other mode leaves it unchanged.
- R10: `cpu_clk_en` is 1 only when the block is settled in RUN. It is 0 in every other mode and during the settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested mode code |
| periph_wake | input | 1 | Peripheral interrupt wake event |
| dbg_wake | input | 1 | Debug-port wake |
| ext_rst_wake | input | 1 | External reset pin wake |
| io_match | input | IO_W | Level-match hits on designated IO inputs |
| settle_cnt | input | CNT_W | Cycles of clock hold-off after a wake, minus one |
| reinit_clr | input | 1 | Software clears the reinit flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| hp_clk_en | output | 1 | Fast-domain clock enable |
| hp_pwr_en | output | 1 | Fast-domain power enable |
| ls_clk_en | output | 1 | Slow-domain clock enable |
| ls_pwr_en | output | 1 | Slow-domain power enable |
| core_reg_en | output | 1 | Core regulator enable |
| mode_code | output | 3 | Current mode code |
| reinit_req | output | 1 | Domain reconfiguration required |

## Verification
The assertions assume that `rst` is high at the first clock edge, so that every `$past` term refers to a defined state. They also assume that all inputs are stable around the rising edge. The stimulus meets both conditions: it holds reset high for several edges before releasing it, and it changes every input only 2 ns after a rising edge. Wake inputs and requests are dropped within the cycle that follows their use. This keeps each transition tied to a single known edge. `settle_cnt` is held steady across each wake, so the expected hold-off can be computed from the value sampled at that edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_RUN   = 3'd0,
        M_SLEEP = 3'd1,
        M_STOP  = 3'd2,
        M_STBY  = 3'd3,
        M_SHDN  = 3'd4
    } mode_t;

    typedef enum logic [1:0] {
        PH_STEADY = 2'd0,
        PH_CLKOFF = 2'd1,
        PH_SETTLE = 2'd2
    } phase_t;

    typedef struct packed {
        logic cpu_clk;
        logic hp_clk;
        logic hp_pwr;
        logic ls_clk;
        logic ls_pwr;
        logic core;
    } gate_t;

    // Settled gating pattern of each mode.
    function automatic gate_t mode_gate(mode_t m);
        gate_t g;
        case (m)
            M_RUN:   g = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            M_SLEEP: g = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            M_STOP:  g = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
            M_STBY:  g = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            default: g = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
        endcase
        return g;
    endfunction

    // Clocks from one pattern, power held fully on.
    function automatic gate_t clocks_only(gate_t g);
        gate_t r;
        r         = g;
        r.hp_pwr  = 1'b1;
        r.ls_pwr  = 1'b1;
        r.core    = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/lpm_req_filter.sv
module lpm_req_filter
    import lpm_pkg::*;
(
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    output logic              req_ok,
    output mode_t             req_target
);
    always_comb begin
        req_target = mode_t'(req_mode);
        req_ok     = req_valid &&
                     (req_mode >= MODE_W'(M_SLEEP)) &&
                     (req_mode <= MODE_W'(M_SHDN));
    end
endmodule

// File: rtl/lpm_wake_sel.sv
module lpm_wake_sel #(
    parameter int IO_W = 4
) (
    input  logic            periph_wake,
    input  logic            dbg_wake,
    input  logic            ext_rst_wake,
    input  logic [IO_W-1:0] io_match,
    output logic            wake_shdn,
    output logic            wake_light
);
    logic [IO_W:0] io_chain;

    assign io_chain[0] = 1'b0;
    for (genvar i = 0; i < IO_W; i++) begin : g_io
        assign io_chain[i+1] = io_chain[i] | io_match[i];
    end

    assign wake_shdn  = dbg_wake | ext_rst_wake | io_chain[IO_W];
    assign wake_light = wake_shdn | periph_wake;
endmodule

// File: rtl/lpm_settle_ctr.sv
module lpm_settle_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val))) else $error("settle load"); // R7
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int IO_W  = 4,
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              periph_wake,
    input  logic              dbg_wake,
    input  logic              ext_rst_wake,
    input  logic [IO_W-1:0]   io_match,
    input  logic [CNT_W-1:0]  settle_cnt,
    input  logic              reinit_clr,
    output logic              cpu_clk_en,
    output logic              hp_clk_en,
    output logic              hp_pwr_en,
    output logic              ls_clk_en,
    output logic              ls_pwr_en,
    output logic              core_reg_en,
    output logic [2:0]        mode_code,
    output logic              reinit_req
);
    mode_t  cur_mode, from_mode, req_target;
    phase_t phase;
    logic   req_ok, wake_shdn, wake_light, settle_done;
    logic   take_req, take_wake, reinit_q;
    gate_t  gate;

    lpm_req_filter u_req (
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_ok     (req_ok),
        .req_target (req_target)
    );

    lpm_wake_sel #(.IO_W(IO_W)) u_wake (
        .periph_wake  (periph_wake),
        .dbg_wake     (dbg_wake),
        .ext_rst_wake (ext_rst_wake),
        .io_match     (io_match),
        .wake_shdn    (wake_shdn),
        .wake_light   (wake_light)
    );

    always_comb begin
        take_req  = (phase == PH_STEADY) && (cur_mode == M_RUN) && req_ok;
        take_wake = (phase == PH_STEADY) && (cur_mode != M_RUN) &&
                    ((cur_mode == M_SHDN) ? wake_shdn : wake_light);
    end

    lpm_settle_ctr #(.CNT_W(CNT_W)) u_settle (
        .clk      (clk),
        .rst      (rst),
        .load     (take_wake),
        .load_val (settle_cnt),
        .done     (settle_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_mode  <= M_RUN;
            from_mode <= M_RUN;
            phase     <= PH_STEADY;
        end else begin
            case (phase)
                PH_STEADY: begin
                    if (take_req) begin
                        cur_mode <= req_target;
                        phase    <= PH_CLKOFF;
                    end else if (take_wake) begin
                        from_mode <= cur_mode;
                        cur_mode  <= M_RUN;
                        phase     <= PH_SETTLE;
                    end
                end
                PH_CLKOFF: phase <= PH_STEADY;
                PH_SETTLE: if (settle_done) phase <= PH_STEADY;
                default:   phase <= PH_STEADY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                reinit_q <= 1'b0;
        else if (take_wake && cur_mode == M_SHDN) reinit_q <= 1'b1;
        else if (reinit_clr)                    reinit_q <= 1'b0;
    end

    always_comb begin
        case (phase)
            PH_CLKOFF: gate = clocks_only(mode_gate(cur_mode));
            PH_SETTLE: gate = clocks_only(mode_gate(from_mode));
            default:   gate = mode_gate(cur_mode);
        endcase
    end

    assign cpu_clk_en  = gate.cpu_clk;
    assign hp_clk_en   = gate.hp_clk;
    assign hp_pwr_en   = gate.hp_pwr;
    assign ls_clk_en   = gate.ls_clk;
    assign ls_pwr_en   = gate.ls_pwr;
    assign core_reg_en = gate.core;
    assign mode_code   = cur_mode;
    assign reinit_req  = reinit_q;

    AST_CPU_ONLY_RUN: assert property (@(posedge clk) disable iff (rst)
        cpu_clk_en |-> (mode_code == 3'd0)) else $error("cpu clk"); // R10
    AST_HP_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        hp_clk_en |-> hp_pwr_en) else $error("hp clk"); // R4
    AST_LS_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (rst)
        ls_clk_en |-> ls_pwr_en) else $error("ls clk"); // R4
    AST_CLK_BEFORE_PWR: assert property (@(posedge clk) disable iff (rst)
        $fell(hp_pwr_en) |-> $past(!hp_clk_en)) else $error("order"); // R4
    AST_REG_OFF_SHDN: assert property (@(posedge clk) disable iff (rst)
        !core_reg_en |-> (!hp_pwr_en && !ls_pwr_en && mode_code == 3'd4)) else $error("reg"); // R3
    AST_SHDN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STEADY && cur_mode == M_SHDN && !wake_shdn) |=> (mode_code == 3'd4)) else $error("shdn"); // R6
    AST_EXIT_TO_RUN: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_code) != 3'd0 && mode_code != $past(mode_code)) |-> (mode_code == 3'd0)) else $error("exit"); // R2
    AST_REINIT_SET: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_code) == 3'd4 && mode_code == 3'd0) |-> reinit_req) else $error("reinit"); // R9
endmodule

// File: tb/sim_lpm_sequencer.sv
`timescale 1ns/1ps
module sim_lpm_sequencer;
    localparam int IO_W  = 4;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic periph_wake = 1'b0, dbg_wake = 1'b0, ext_rst_wake = 1'b0;
    logic [IO_W-1:0] io_match = '0;
    logic [CNT_W-1:0] settle_cnt = '0;
    logic reinit_clr = 1'b0;
    logic cpu_clk_en, hp_clk_en, hp_pwr_en, ls_clk_en, ls_pwr_en, core_reg_en;
    logic [2:0] mode_code;
    logic reinit_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lpm_sequencer #(.IO_W(IO_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .periph_wake(periph_wake), .dbg_wake(dbg_wake), .ext_rst_wake(ext_rst_wake),
        .io_match(io_match), .settle_cnt(settle_cnt), .reinit_clr(reinit_clr),
        .cpu_clk_en(cpu_clk_en), .hp_clk_en(hp_clk_en), .hp_pwr_en(hp_pwr_en),
        .ls_clk_en(ls_clk_en), .ls_pwr_en(ls_pwr_en), .core_reg_en(core_reg_en),
        .mode_code(mode_code), .reinit_req(reinit_req)
    );

    // {mode[2:0], wake source[1:0], settled pattern[5:0], reinit}
    // wake source: 0 periph, 1 debug, 2 ext reset, 3 io match
    localparam logic [11:0] VEC [8] = '{
        {3'd1, 2'd0, 6'b011111, 1'b0},
        {3'd2, 2'd0, 6'b000111, 1'b0},
        {3'd3, 2'd0, 6'b000011, 1'b0},
        {3'd4, 2'd1, 6'b000000, 1'b1},
        {3'd4, 2'd2, 6'b000000, 1'b1},
        {3'd4, 2'd3, 6'b000000, 1'b1},
        {3'd2, 2'd1, 6'b000111, 1'b0},
        {3'd3, 2'd3, 6'b000011, 1'b0}
    };

    function automatic logic [5:0] obs();
        return {cpu_clk_en, hp_clk_en, hp_pwr_en, ls_clk_en, ls_pwr_en, core_reg_en};
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic enter(logic [2:0] m);
        req_valid = 1'b1;
        req_mode  = m;
        step();
        req_valid = 1'b0;
    endtask

    task automatic drive_wake(logic [1:0] src, logic on);
        periph_wake  = on && src == 2'd0;
        dbg_wake     = on && src == 2'd1;
        ext_rst_wake = on && src == 2'd2;
        io_match     = (on && src == 2'd3) ? 4'b0100 : 4'b0000;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        check("R1", "mode at reset", 32'(mode_code), 0);
        check("R1", "enables at reset", 32'(obs()), 32'h3f);
        check("R1", "reinit at reset", 32'(reinit_req), 0);
        rst = 1'b0;
        step();

        // Vector walk: entry, settled pattern, wake, settle window.
        for (int i = 0; i < 8; i++) begin
            logic [2:0] vm;
            logic [1:0] vw;
            logic [5:0] vp;
            logic       vr;
            int         s;
            {vm, vw, vp, vr} = VEC[i];
            s = i % 3;
            settle_cnt = CNT_W'(s);
            enter(vm);
            check("R4", "clocks drop first", 32'(obs()), 32'(vp | 6'b001011));
            check("R8", "mode code after request", 32'(mode_code), 32'(vm));
            step();
            check("R3", "settled pattern", 32'(obs()), 32'(vp));
            drive_wake(vw, 1'b1);
            step();
            drive_wake(vw, 1'b0);
            check(vm == 3'd4 ? "R6" : "R5", "mode after wake", 32'(mode_code), 0);
            check("R7", "power first on wake", 32'(obs()), 32'(vp | 6'b001011));
            check("R9", "reinit after wake", 32'(reinit_req), 32'(vr));
            for (int j = 0; j < s; j++) begin
                step();
                check("R10", "clocks held in settle", 32'(obs()), 32'(vp | 6'b001011));
            end
            step();
            check("R7", "clocks back after settle", 32'(obs()), 32'h3f);
            reinit_clr = 1'b1;
            step();
            reinit_clr = 1'b0;
            check("R9", "reinit cleared", 32'(reinit_req), 0);
        end

        // R2: invalid codes ignored in RUN.
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c >= 5) begin
                enter(3'(c));
                check("R2", "invalid code mode", 32'(mode_code), 0);
                check("R2", "invalid code enables", 32'(obs()), 32'h3f);
            end
        end

        // R2: request while in STOP is ignored.
        enter(3'd2);
        step();
        enter(3'd1);
        step();
        check("R2", "request outside RUN mode", 32'(mode_code), 2);
        check("R2", "request outside RUN enables", 32'(obs()), 32'b000111);

        // R10: wake from STOP with long settle keeps CPU clock off.
        settle_cnt = 8'd5;
        periph_wake = 1'b1;
        step();
        periph_wake = 1'b0;
        repeat (3) step();
        check("R10", "cpu clock in settle", 32'(cpu_clk_en), 0);
        repeat (3) step();
        check("R10", "cpu clock after settle", 32'(cpu_clk_en), 1);

        // R6: SHUTDOWN ignores peripheral interrupt.
        settle_cnt = 8'd0;
        enter(3'd4);
        step();
        periph_wake = 1'b1;
        repeat (3) step();
        periph_wake = 1'b0;
        check("R6", "periph wake in shutdown mode", 32'(mode_code), 4);
        check("R6", "periph wake in shutdown enables", 32'(obs()), 0);

        // R9: set wins over clear in the same cycle.
        reinit_clr = 1'b1;
        io_match = 4'b0001;
        step();
        io_match = 4'b0000;
        reinit_clr = 1'b0;
        check("R9", "set beats clear", 32'(reinit_req), 1);
        step();
        check("R7", "zero settle restores clocks", 32'(obs()), 32'h3f);

        // R1: reset from a low-power mode.
        reinit_clr = 1'b1;
        step();
        reinit_clr = 1'b0;
        enter(3'd3);
        step();
        rst = 1'b1;
        step();
        check("R1", "reset from standby mode", 32'(mode_code), 0);
        check("R1", "reset from standby enables", 32'(obs()), 32'h3f);
        rst = 1'b0;
        step();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule